// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when a multi-channel analog-to-digital converter begins a conversion sequence. A sequence can be started by a software strobe, or by an external trigger pin once the trigger is enabled. The pin can be used in edge mode, where one sequence runs per active edge, or in level mode, where sequences repeat back to back while the pin stays active. A polarity bit selects which edge or level counts as active. The conversion engine itself is outside the block. It receives a one-cycle `seqStart` pulse and reports the end of each sequence with a `seqDone` pulse. The block drives `seqBusy` for the whole span of a run.

Before it is used, the trigger pin passes through a synchronizer chain. In edge mode, an active edge that arrives while a sequence is already running does not start anything. It sets a sticky overrun flag instead, and that flag stays set until software clears it. In level mode, if the pin is still active when a sequence finishes, the next sequence starts with no idle cycle in between. A level pin that drops and returns during a sequence is not treated as an overrun.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `seqStart`, `seqBusy` and `ovrFlag` are all 0.
- R2: With `trigEn`=0, the pin is ignored. A `swStart` strobe seen while idle makes `seqStart` pulse for one cycle, starting in the cycle after the strobe, and `seqBusy` rises in that same cycle. With `scanCont`=0, `seqBusy` returns to 0 in the cycle after `seqDone`.
- R3: With `trigEn`=0 and `scanCont`=1, a software-started run restarts on each `seqDone`. `seqStart` pulses in the next cycle and `seqBusy` stays 1. Once `scanCont` is 0 at a `seqDone`, the run ends.
- R4: With `trigEn`=1, `swStart` has no effect.
- R5: With `trigEn`=1 and `levelMode`=0, `trigPol`=0 makes a falling pin edge start one sequence and `trigPol`=1 makes a rising edge start one. `seqStart` appears at the third rising clock edge after the pin change, counting the edge that samples the change.
- R6: In edge mode, the inactive edge starts nothing, and an active edge seen while `seqBusy`=1 starts no extra sequence.
- R7: In edge mode, an active edge seen while `seqBusy`=1 sets `ovrFlag`. This includes the cycle in which `seqDone` is given.
- R8: `ovrFlag` stays 1 until `ovrClr` is pulsed. If a clear and a new overrun fall in the same cycle, the flag ends up 1.
- R9: With `trigEn`=1 and `levelMode`=1, a sequence starts while the pin equals `trigPol`. If the pin is still active at `seqDone`, `seqStart` pulses in the next cycle and `seqBusy` never drops.
- R10: In level mode, a pin that drops and returns during a sequence never sets `ovrFlag`. If the pin is inactive at `seqDone`, the block goes idle.
- R11: Changing `trigEn`, `levelMode` or `trigPol` during a sequence does not end it. `seqBusy` stays 1 until `seqDone`.
- R12: `seqDone` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigPin | input | 1 | External trigger pin (asynchronous) |
| swStart | input | 1 | Software start strobe |
| trigEn | input | 1 | 1: only the pin may start sequences |
| levelMode | input | 1 | 0: edge mode, 1: level mode |
| trigPol | input | 1 | 0: falling edge / low level, 1: rising edge / high level |
| scanCont | input | 1 | Continuous software scan when 1 |
| ovrClr | input | 1 | Clears the overrun flag |
| seqDone | input | 1 | Engine reports the end of a sequence |
| seqStart | output | 1 | One-cycle start pulse to the engine |
| seqBusy | output | 1 | A sequence is running |
| ovrFlag | output | 1 | Sticky trigger overrun flag |

## Verification
The start path is exercised with software strobes in single and continuous scan, with falling and rising pin edges under both polarities, and with a pin held high or held low in level mode. Pairing each active edge with its opposite edge shows whether polarity is decoded correctly. Edges that arrive while a sequence runs, compared against a level pin that dips and comes back, show whether overrun detection is limited to edge mode. Ending a sequence with the level still held, compared against ending it with the level released, shows whether a gapless restart is told apart from a return to idle. Writes to the mode bits and software strobes in the middle of a sequence confirm that a run in progress is neither aborted nor restarted.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  // Conditions derived from the synchronized trigger pin
  typedef struct packed {
    logic actLevel;  // pin currently at active level
    logic actEdge;   // pin just moved into active level
  } trigSenseT;

  // Strobes from control to datapath registers
  typedef struct packed {
    logic fire;      // launch a sequence next cycle
    logic finish;    // current sequence ends this cycle
    logic ovrSet;    // record an overrun
    logic ovrClr;    // software clear of the overrun flag
  } ctrlStrobeT;

endpackage

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigPin,
  input  logic       trigPol,
  input  ctrlStrobeT strobes,
  output trigSenseT  sense,
  output logic       startQ,
  output logic       busyQ,
  output logic       ovrQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          pinNow;

  // Synchronizer chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= trigPin;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign pinNow = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= pinNow;
  end

  always_comb begin
    sense.actLevel = (pinNow == trigPol);
    sense.actEdge  = (pinNow == trigPol) && (prevQ != trigPol);
  end

  // Handshake and flag registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= 1'b0;
      busyQ  <= 1'b0;
      ovrQ   <= 1'b0;
    end else begin
      startQ <= strobes.fire;
      busyQ  <= strobes.fire | (busyQ & ~strobes.finish);
      ovrQ   <= strobes.ovrSet | (ovrQ & ~strobes.ovrClr);
    end
  end

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swStart,
  input  logic       trigEn,
  input  logic       levelMode,
  input  logic       scanCont,
  input  logic       ovrClr,
  input  logic       seqDone,
  input  logic       busy,
  input  trigSenseT  sense,
  output ctrlStrobeT strobes
);

  logic srcSwQ;     // current run launched by software
  logic idleStart;
  logic doneNow;
  logic restart;
  logic extCond;

  always_comb begin
    extCond   = levelMode ? sense.actLevel : sense.actEdge;
    idleStart = !busy && (trigEn ? extCond : swStart);
    doneNow   = busy && seqDone;
    restart   = doneNow && (trigEn ? (levelMode && sense.actLevel)
                                   : (scanCont && srcSwQ));
    strobes.fire   = idleStart | restart;
    strobes.finish = doneNow;
    strobes.ovrSet = trigEn && !levelMode && sense.actEdge && busy;
    strobes.ovrClr = ovrClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             srcSwQ <= 1'b0;
    else if (strobes.fire) srcSwQ <= !trigEn;
  end

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigPin,
  input  logic swStart,
  input  logic trigEn,
  input  logic levelMode,
  input  logic trigPol,
  input  logic scanCont,
  input  logic ovrClr,
  input  logic seqDone,
  output logic seqStart,
  output logic seqBusy,
  output logic ovrFlag
);

  trigSenseT  sense;
  ctrlStrobeT strobes;

  adc_trig_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .swStart(swStart), .trigEn(trigEn),
    .levelMode(levelMode), .scanCont(scanCont), .ovrClr(ovrClr),
    .seqDone(seqDone), .busy(seqBusy), .sense(sense), .strobes(strobes)
  );

  adc_trig_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .trigPol(trigPol),
    .strobes(strobes), .sense(sense), .startQ(seqStart),
    .busyQ(seqBusy), .ovrQ(ovrFlag)
  );

endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk (
  input logic clk,
  input logic rstN,
  input logic trigPin,
  input logic swStart,
  input logic trigEn,
  input logic levelMode,
  input logic trigPol,
  input logic scanCont,
  input logic ovrClr,
  input logic seqDone,
  input logic seqStart,
  input logic seqBusy,
  input logic ovrFlag
);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |-> seqBusy);

  assert_sw_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!seqBusy && !trigEn && !swStart) |=> !seqStart);

  assert_cont_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && seqDone && !trigEn && !scanCont) |=> !seqBusy);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !ovrClr) |=> ovrFlag);

  assert_no_level_ovr_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((!trigEn || levelMode) && !ovrFlag) |=> !ovrFlag);

  assert_no_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && !seqDone) |=> seqBusy);

  assert_idle_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!seqBusy && seqDone && !trigEn && !swStart) |=> !seqBusy);

endmodule

bind adc_trig_seq adc_trig_seq_chk chk_i (.*);

// File: tb/adc_trig_seq_tb_top.sv
module adc_trig_seq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigPin = 1'b0, swStart = 1'b0, trigEn = 1'b0, levelMode = 1'b0;
  logic trigPol = 1'b0, scanCont = 1'b0, ovrClr = 1'b0, seqDone = 1'b0;
  logic seqStart, seqBusy, ovrFlag;

  int nChecks = 0;
  int nFails = 0;
  int starts = 0;

  always #10 clk = ~clk;  // 50 MHz

  adc_trig_seq dut_i (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .swStart(swStart),
    .trigEn(trigEn), .levelMode(levelMode), .trigPol(trigPol),
    .scanCont(scanCont), .ovrClr(ovrClr), .seqDone(seqDone),
    .seqStart(seqStart), .seqBusy(seqBusy), .ovrFlag(ovrFlag)
  );

  always @(negedge clk) if (seqStart) starts++;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseDone();
    seqDone = 1'b1; tick(1); seqDone = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "seqStart after reset", int'(seqStart), 0);
    check("R1", "seqBusy after reset", int'(seqBusy), 0);
    check("R1", "ovrFlag after reset", int'(ovrFlag), 0);
  endtask

  task automatic tSwSingle();
    int s0;
    trigEn = 0; scanCont = 0;
    seqDone = 1'b1; tick(1); seqDone = 1'b0; tick(1);
    check("R12", "busy after idle done", int'(seqBusy), 0);
    s0 = starts;
    swStart = 1'b1; tick(1); swStart = 1'b0;
    check("R2", "sw start pulse", int'(seqStart), 1);
    check("R2", "busy with start", int'(seqBusy), 1);
    tick(3);
    check("R2", "start is one cycle", int'(seqStart), 0);
    pulseDone();
    check("R2", "busy after done", int'(seqBusy), 0);
    tick(2);
    check("R2", "single start count", starts - s0, 1);
  endtask

  task automatic tSwCont();
    int s0;
    int dropped;
    s0 = starts; dropped = 0;
    trigEn = 0; scanCont = 1;
    swStart = 1'b1; tick(1); swStart = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick(2);
      if (!seqBusy) dropped++;
      pulseDone();
      check("R3", "restart pulse", int'(seqStart), 1);
      if (!seqBusy) dropped++;
    end
    check("R3", "busy drops in cont scan", dropped, 0);
    scanCont = 0; tick(2);
    pulseDone();
    check("R3", "run ends without scan", int'(seqBusy), 0);
    tick(2);
    check("R3", "cont start count", starts - s0, 4);
  endtask

  task automatic tPinIgnored();
    int s0;
    s0 = starts;
    trigEn = 0; scanCont = 0;
    for (int k = 0; k < 4; k++) begin
      trigPin = ~trigPin; tick(4);
    end
    check("R2", "pin ignored starts", starts - s0, 0);
    check("R2", "pin ignored busy", int'(seqBusy), 0);
  endtask

  task automatic tSwBlocked();
    int s0;
    trigPin = 0; tick(4);
    trigEn = 1; levelMode = 0; trigPol = 1; tick(2);
    s0 = starts;
    swStart = 1'b1; tick(1); swStart = 1'b0; tick(3);
    check("R4", "sw start blocked", starts - s0, 0);
    check("R4", "busy stays low", int'(seqBusy), 0);
  endtask

  task automatic edgeCase(input logic pol);
    int s0;
    trigEn = 0; trigPin = ~pol; tick(4);
    trigEn = 1; levelMode = 0; trigPol = pol; tick(2);
    s0 = starts;
    trigPin = pol; tick(2);
    check("R5", "no start before latency", int'(seqStart), 0);
    tick(1);
    check("R5", "edge start at latency", int'(seqStart), 1);
    check("R5", "busy with edge start", int'(seqBusy), 1);
    tick(2);
    pulseDone();
    check("R5", "idle after edge seq", int'(seqBusy), 0);
    trigPin = ~pol; tick(5);
    check("R6", "inactive edge no start", starts - s0, 1);
    check("R6", "inactive edge busy", int'(seqBusy), 0);
  endtask

  task automatic tOverrun();
    int s0;
    ovrClr = 1; tick(1); ovrClr = 0;
    trigEn = 0; trigPin = 0; tick(4);
    trigEn = 1; levelMode = 0; trigPol = 1; tick(2);
    s0 = starts;
    trigPin = 1; tick(4);
    check("R7", "ovr clear before", int'(ovrFlag), 0);
    trigPin = 0; tick(4);
    trigPin = 1; tick(4);
    check("R7", "overrun set", int'(ovrFlag), 1);
    check("R6", "no extra start while busy", starts - s0, 1);
    tick(5);
    check("R8", "overrun sticky", int'(ovrFlag), 1);
    ovrClr = 1; tick(1); ovrClr = 0;
    check("R8", "overrun cleared", int'(ovrFlag), 0);
    // clear in the same cycle as a new overrun
    trigPin = 0; tick(4);
    trigPin = 1; tick(2);
    ovrClr = 1; tick(1); ovrClr = 0;
    check("R8", "set wins over clear", int'(ovrFlag), 1);
    ovrClr = 1; tick(1); ovrClr = 0;
    // edge lined up with the done cycle
    trigPin = 0; tick(4);
    trigPin = 1; tick(2);
    pulseDone();
    check("R7", "overrun at done cycle", int'(ovrFlag), 1);
    check("R7", "idle after done", int'(seqBusy), 0);
    tick(3);
    check("R6", "edge at done no start", starts - s0, 1);
    ovrClr = 1; tick(1); ovrClr = 0;
  endtask

  task automatic levelCase(input logic pol);
    int s0;
    int dropped;
    dropped = 0;
    trigEn = 0; trigPin = ~pol; tick(4);
    trigEn = 1; levelMode = 1; trigPol = pol; tick(2);
    ovrClr = 1; tick(1); ovrClr = 0;
    s0 = starts;
    trigPin = pol; tick(3);
    check("R9", "level start", int'(seqStart), 1);
    tick(2);
    pulseDone();
    check("R9", "level restart pulse", int'(seqStart), 1);
    if (!seqBusy) dropped++;
    // drop and return mid-sequence
    trigPin = ~pol; tick(3);
    if (!seqBusy) dropped++;
    trigPin = pol; tick(4);
    check("R10", "no overrun on level glitch", int'(ovrFlag), 0);
    check("R9", "busy never dropped", dropped, 0);
    check("R10", "glitch no extra start", starts - s0, 2);
    trigPin = ~pol; tick(4);
    pulseDone();
    check("R10", "idle after inactive level", int'(seqBusy), 0);
    tick(3);
    check("R10", "no restart when inactive", starts - s0, 2);
  endtask

  task automatic tModeChange();
    trigEn = 0; scanCont = 0; trigPin = 1; tick(4);
    swStart = 1'b1; tick(1); swStart = 1'b0;
    trigEn = 1; levelMode = 1; trigPol = 0; tick(1);
    trigPol = 1; levelMode = 0; tick(3);
    check("R11", "busy after mode change", int'(seqBusy), 1);
    swStart = 1'b1; tick(1); swStart = 1'b0; tick(2);
    check("R11", "still busy", int'(seqBusy), 1);
    trigPin = 0; trigEn = 1; levelMode = 1; trigPol = 1; tick(4);
    pulseDone();
    check("R11", "ends at done", int'(seqBusy), 0);
    trigEn = 0;
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    tReset();
    tSwSingle();
    tSwCont();
    tPinIgnored();
    tSwBlocked();
    edgeCase(1'b0);
    edgeCase(1'b1);
    tOverrun();
    levelCase(1'b1);
    levelCase(1'b0);
    tModeChange();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule